// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns the full `2*WIDTH`-bit signed product. It is a multi-cycle unit. A single start pulse captures both operands. The block then performs one Booth step per clock until all multiplier bits have been consumed. After that it raises a one-cycle completion strobe and holds the product until the next accepted start.

Each step looks at the lowest bit of the multiplier register together with the bit that was shifted out in the previous step. From that pair it decides whether to add the multiplicand to the upper half, subtract it, or leave the upper half alone. The upper half, the multiplier register and the extra trailing bit then shift right together as one arithmetic unit. Negative operands need no pre- or post-correction. The upper half carries one bit of headroom, so the most negative multiplicand never overflows it.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `product_o` is zero.
- R2: A start is accepted at a rising edge where `start_i` is high and `busy_o` is low. `busy_o` is then high for exactly `WIDTH` cycles. On the following cycle `done_o` is high for exactly one cycle while `busy_o` is low.
- R3: When `done_o` is high, `product_o` equals the signed product of the two operands captured at the accepted start. The product is sign-extended to `2*WIDTH` bits, and this holds for every operand pair, including the most negative values.
- R4: A `start_i` pulse while `busy_o` is high is ignored. The running operation finishes with the originally captured operands and the original timing.
- R5: `product_o` keeps its value from the `done_o` cycle until the next accepted start.
- R6: The step taken for each (current, previous) multiplier bit pair is fixed. Pairs 00 and 11 leave the upper half unchanged. Pair 01 adds the multiplicand. Pair 10 subtracts it. The previous bit starts at 0.
- R7: The upper half is `WIDTH+1` bits wide, and its two top bits always agree, so no step ever overflows it.
- R8: A start raised in the same cycle that `done_o` is high is accepted, giving back-to-back operations with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a multiplication |
| multiplicand_i | input | WIDTH | Signed multiplicand, sampled on an accepted start |
| multiplier_i | input | WIDTH | Signed multiplier, sampled on an accepted start |
| busy_o | output | 1 | High while Booth steps are running |
| done_o | output | 1 | One-cycle strobe marking a valid new product |
| product_o | output | 2*WIDTH | Signed product |

## Verification
The assertions assume that the operand inputs matter only at an accepted start. They also assume that `start_i` may be raised at any time, including while busy and on the completion cycle. The directed tasks drive `start_i` and the operands on the falling clock edge. They deliberately raise start in the middle of an operation with different operands, and again on the `done_o` cycle. The bench also holds start low after completion so that the product-hold property is exercised. The bench sets `WIDTH` to 6, which makes it practical to sweep every operand pair against a behavioural signed multiply.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;

   typedef enum logic [1:0] {
      BOOTH_HOLD = 2'd0,
      BOOTH_ADD  = 2'd1,
      BOOTH_SUB  = 2'd2
   } booth_op_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_mult_pkg::*;
(
   input  logic      cur_bit_i,
   input  logic      prev_bit_i,
   output booth_op_e op_o
);

   always_comb begin
      unique case ({cur_bit_i, prev_bit_i})
         2'b01:   op_o = BOOTH_ADD;
         2'b10:   op_o = BOOTH_SUB;
         default: op_o = BOOTH_HOLD;
      endcase
   end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import booth_mult_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit XOR_SUB = 1'b1
) (
   input  logic [WIDTH:0]   acc_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  booth_op_e        op_i,
   output logic [WIDTH:0]   sum_o
);

   localparam int EXT_W = WIDTH + 1;

   logic [EXT_W-1:0] mcand_ext;
   assign mcand_ext = {mcand_i[WIDTH-1], mcand_i};

   generate
      if (XOR_SUB) begin : g_xor
         // One adder: invert through XOR and inject +1 on subtract.
         logic             do_sub;
         logic [EXT_W-1:0] addend;
         assign do_sub = (op_i == BOOTH_SUB);
         assign addend = (op_i == BOOTH_HOLD) ? '0
                         : (mcand_ext ^ {EXT_W{do_sub}});
         assign sum_o  = acc_i + addend + {{(EXT_W-1){1'b0}}, do_sub};
      end else begin : g_mux
         always_comb begin
            unique case (op_i)
               BOOTH_ADD: sum_o = acc_i + mcand_ext;
               BOOTH_SUB: sum_o = acc_i - mcand_ext;
               default:   sum_o = acc_i;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);

   localparam int CNT_W = $clog2(WIDTH + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;

   assign load_o = start_i && !busy_q;
   assign step_o = busy_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   // R2: the strobe lasts one cycle and never overlaps busy
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o));
   a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(busy_o));
   a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cnt_q <= LAST));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
   import booth_mult_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit XOR_SUB = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [WIDTH-1:0]     multiplicand_i,
   input  logic [WIDTH-1:0]     multiplier_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [2*WIDTH-1:0]   product_o
);

   localparam int ACC_W  = WIDTH + 1;
   localparam int PROD_W = 2 * WIDTH;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("booth_seq_mult: WIDTH must be at least 2");
      end
   endgenerate

   logic [ACC_W-1:0] acc_q;
   logic [WIDTH-1:0] mplr_q;
   logic [WIDTH-1:0] mcand_q;
   logic             prev_q;

   logic             load;
   logic             step;
   booth_op_e        op;
   logic [ACC_W-1:0] sum;

   booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .step_o  (step),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   booth_recoder u_rec (
      .cur_bit_i  (mplr_q[0]),
      .prev_bit_i (prev_q),
      .op_o       (op)
   );

   booth_addsub #(.WIDTH(WIDTH), .XOR_SUB(XOR_SUB)) u_add (
      .acc_i   (acc_q),
      .mcand_i (mcand_q),
      .op_i    (op),
      .sum_o   (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         mplr_q  <= '0;
         mcand_q <= '0;
         prev_q  <= 1'b0;
      end else if (load) begin
         acc_q   <= '0;
         mplr_q  <= multiplier_i;
         mcand_q <= multiplicand_i;
         prev_q  <= 1'b0;
      end else if (step) begin
         // arithmetic shift of {sum, mplr, prev} by one
         acc_q   <= {sum[ACC_W-1], sum[ACC_W-1:1]};
         mplr_q  <= {sum[0], mplr_q[WIDTH-1:1]};
         prev_q  <= mplr_q[0];
      end
   end

   assign product_o = {acc_q[WIDTH-1:0], mplr_q};

   // R7: headroom bit always matches the sign of the upper half
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q[ACC_W-1] == acc_q[WIDTH-1]);
   // R4: a start during an operation leaves the captured multiplicand alone
   a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (mcand_q == $past(mcand_q)));
   // R5: the idle product does not move without an accepted start
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(product_o));
   // R6: the previous bit is the one just shifted out
   a_r6_prev_bit: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (prev_q == $past(mplr_q[0])));

endmodule

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;

   localparam int W  = 6;
   localparam int PW = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [W-1:0]  multiplicand_i = '0;
   logic [W-1:0]  multiplier_i = '0;
   logic          busy_o;
   logic          done_o;
   logic [PW-1:0] product_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   booth_seq_mult #(.WIDTH(W)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .multiplicand_i (multiplicand_i),
      .multiplier_i   (multiplier_i),
      .busy_o         (busy_o),
      .done_o         (done_o),
      .product_o      (product_o)
   );

   function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      longint p;
      p = longint'($signed(a)) * longint'($signed(b));
      return p[PW-1:0];
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // Drive start at a falling edge; wait for done; check latency and product.
   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
      int lat;
      bit busy_ok;
      @(negedge clk);
      start_i = 1'b1; multiplicand_i = a; multiplier_i = b;
      @(negedge clk);
      start_i = 1'b0;
      lat = 1; busy_ok = 1'b1;
      while (!done_o && lat < W + 8) begin
         if (!busy_o) busy_ok = 1'b0;
         @(negedge clk);
         lat++;
      end
      check(lat == W + 1 && busy_ok && !busy_o, "R2 latency", lat, W + 1);
      check(product_o == ref_mul(a, b), req, product_o, ref_mul(a, b));
   endtask

   task automatic t_reset();
      check(!busy_o && !done_o && product_o == '0, "R1 reset state",
            {busy_o, done_o, product_o}, 0);
   endtask

   task automatic t_patterns();
      run_op(6'b011111, 6'b111111, "R6 multiplier all ones");
      run_op(6'b010011, 6'b010101, "R6 alternating multiplier");
      run_op(6'b101101, 6'b001110, "R6 run of ones");
      run_op(6'b100000, 6'b100000, "R3 most negative squared");
      run_op(6'b100000, 6'b011111, "R7 most negative times max");
      run_op(6'b000000, 6'b101010, "R3 zero multiplicand");
   endtask

   task automatic t_exhaustive();
      for (int i = 0; i < (1 << W); i++) begin
         for (int j = 0; j < (1 << W); j++) begin
            run_op(W'(i), W'(j), "R3 exhaustive");
         end
      end
   endtask

   task automatic t_start_busy();
      int lat;
      @(negedge clk);
      start_i = 1'b1; multiplicand_i = 6'd13; multiplier_i = 6'b111011;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      start_i = 1'b1; multiplicand_i = 6'd31; multiplier_i = 6'd31;
      @(negedge clk);
      start_i = 1'b0;
      lat = 3;
      while (!done_o && lat < W + 8) begin
         @(negedge clk);
         lat++;
      end
      check(lat == W + 1, "R4 timing unchanged", lat, W + 1);
      check(product_o == ref_mul(6'd13, 6'b111011), "R4 start ignored",
            product_o, ref_mul(6'd13, 6'b111011));
   endtask

   task automatic t_hold();
      logic [PW-1:0] exp;
      run_op(6'b110001, 6'd21, "R3 before hold");
      exp = ref_mul(6'b110001, 6'd21);
      multiplicand_i = 6'd7; multiplier_i = 6'd9;
      repeat (5) @(negedge clk);
      check(product_o == exp && !done_o, "R5 product held", product_o, exp);
   endtask

   task automatic t_back_to_back();
      int lat;
      run_op(6'd5, 6'd6, "R3 first of pair");
      // done_o is high now: raise start in this same cycle
      start_i = 1'b1; multiplicand_i = 6'b111110; multiplier_i = 6'd17;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R8 accepted on done", busy_o, 1);
      lat = 1;
      while (!done_o && lat < W + 8) begin
         @(negedge clk);
         lat++;
      end
      check(lat == W + 1, "R8 latency", lat, W + 1);
      check(product_o == ref_mul(6'b111110, 6'd17), "R8 back-to-back product",
            product_o, ref_mul(6'b111110, 6'd17));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_patterns();
      t_start_busy();
      t_hold();
      t_back_to_back();
      t_exhaustive();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

endmodule